// File: doc/BRIEF.md
# Four-bit-coded 32-bit ALU

A purely combinational arithmetic and logic unit for a single-cycle integer datapath. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result, a flag that is high when the result is all zeros, and a signed overflow flag. The zero flag serves equality tests for conditional branches: subtract the operands and look at the flag.

Internally, a decoder turns the operation code into a small set of strobes. The first strobe is a subtract select, which inverts the second operand and forces a carry-in of one on a single shared adder. The second picks between the logic group and the arithmetic group. The third chooses the less-than bit over the sum. The last two pick one of four bitwise operations. A code outside the seven defined ones yields a zero result with overflow low. Nothing in the block is registered.

Top module: `alu32_top`

## Requirements
- R1: Code 4'b0000 gives opA AND opB, 4'b0001 gives OR, 4'b0010 gives XOR, and 4'b0011 gives NOR, all bitwise over 32 bits.
- R2: Code 4'b0110 gives the sum opA + opB modulo 2^32.
- R3: Code 4'b1110 gives the difference opA - opB modulo 2^32.
- R4: Code 4'b1111 gives 32'd1 when opA < opB as two's-complement signed values, and 32'd0 otherwise. This also holds when opA - opB overflows.
- R5: zeroFlag is 1 exactly when all 32 result bits are 0, for every code.
- R6: For add (4'b0110), overflow is 1 when both operands have the same sign and the sum has the other sign. For subtract (4'b1110), overflow is 1 when the operands differ in sign and the difference's sign differs from opA's sign. Otherwise overflow is 0.
- R7: overflow is 0 for the four logic codes and for the less-than code 4'b1111.
- R8: Every other code (4'b0100, 4'b0101, 4'b0111 and 4'b1000 to 4'b1101) gives a result of 0 with overflow 0, and so zeroFlag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, the subtrahend for subtract and less-than |
| aluCode | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
Two cases are hard to reach with ordinary operands. The first is a less-than comparison where opA - opB overflows, so the raw difference sign gives the wrong answer. The second is the boundary between overflow and no overflow for add and subtract. Both only show up with operands near the most negative and most positive values. The stimulus therefore crosses a corner set with itself under every one of the 16 codes. That set includes 0x7FFFFFFF, 0x80000000 and their neighbours, -1, and alternating bit patterns. A stretch of pseudo-random operands follows.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_XOR = 4'b0010;
  localparam logic [3:0] CODE_NOR = 4'b0011;
  localparam logic [3:0] CODE_ADD = 4'b0110;
  localparam logic [3:0] CODE_SUB = 4'b1110;
  localparam logic [3:0] CODE_SLT = 4'b1111;

  typedef struct packed {
    logic       enable;      // code is one of the defined operations
    logic       subtract;    // invert second operand, carry-in one
    logic       arithGroup;  // arithmetic group over logic group
    logic       pickLess;    // less-than bit over the sum
    logic [1:0] logicOp;     // 0 and, 1 or, 2 xor, 3 nor
  } alu_strobe_t;

endpackage

// File: rtl/alu32_ctrl.sv
module alu32_ctrl
  import alu32_pkg::*;
(
  input  logic [3:0]  aluCode,
  output alu_strobe_t strobe
);

  logic known;

  always_comb begin
    unique case (aluCode)
      CODE_AND, CODE_OR, CODE_XOR, CODE_NOR,
      CODE_ADD, CODE_SUB, CODE_SLT: known = 1'b1;
      default:                      known = 1'b0;
    endcase
  end

  always_comb begin
    strobe.enable     = known;
    strobe.subtract   = aluCode[3];
    strobe.arithGroup = aluCode[2];
    strobe.pickLess   = aluCode[0];
    strobe.logicOp    = aluCode[1:0];
  end

endmodule

// File: rtl/alu32_datapath.sv
module alu32_datapath
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic             rawOvf;
  logic             lessBit;

  // per-bit logic unit, four-way select by logicOp
  for (genvar i = 0; i < WIDTH; i++) begin : g_logic
    always_comb begin
      unique case (strobe.logicOp)
        2'd0:    logicOut[i] = opA[i] & opB[i];
        2'd1:    logicOut[i] = opA[i] | opB[i];
        2'd2:    logicOut[i] = opA[i] ^ opB[i];
        default: logicOut[i] = ~(opA[i] | opB[i]);
      endcase
    end
  end

  // shared adder for add, subtract and compare
  always_comb begin
    bEff    = opB ^ {WIDTH{strobe.subtract}};
    sum     = opA + bEff + {{(WIDTH-1){1'b0}}, strobe.subtract};
    rawOvf  = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
    lessBit = sum[MSB] ^ rawOvf;
  end

  always_comb begin
    if (!strobe.enable) begin
      result   = '0;
      overflow = 1'b0;
    end else if (strobe.arithGroup) begin
      result   = strobe.pickLess ? {{(WIDTH-1){1'b0}}, lessBit} : sum;
      overflow = rawOvf & ~strobe.pickLess;
    end else begin
      result   = logicOut;
      overflow = 1'b0;
    end
    zeroFlag = ~|result;
  end

endmodule

// File: rtl/alu32_top.sv
module alu32_top
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       aluCode,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflow
);

  alu_strobe_t strobe;

  alu32_ctrl ctrl_i (
    .aluCode (aluCode),
    .strobe  (strobe)
  );

  alu32_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .zeroFlag (zeroFlag),
    .overflow (overflow)
  );

endmodule

// File: rtl/alu32_checker.sv
module alu32_checker
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       aluCode,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic isLogic;
  logic isKnown;

  always_comb begin
    isLogic = (aluCode[3:2] == 2'b00);
    isKnown = isLogic || aluCode == CODE_ADD || aluCode == CODE_SUB
              || aluCode == CODE_SLT;

    if (aluCode == CODE_AND)
      assert_and_R1: assert (result == (opA & opB)) else $error("R1 and");
    if (aluCode == CODE_NOR)
      assert_nor_R1: assert (result == ~(opA | opB)) else $error("R1 nor");
    if (aluCode == CODE_ADD)
      assert_sum_R2: assert (result == opA + opB) else $error("R2 sum");
    if (aluCode == CODE_SUB)
      assert_diff_R3: assert (result == opA - opB) else $error("R3 diff");
    if (aluCode == CODE_SLT)
      assert_less_R4: assert (result ==
        {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))}) else $error("R4 slt");
    assert_zero_R5: assert (zeroFlag == (result == '0)) else $error("R5 zero");
    if (aluCode == CODE_ADD)
      assert_ovf_add_R6: assert (overflow ==
        ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB]))) else $error("R6 add");
    if (aluCode == CODE_SUB)
      assert_ovf_sub_R6: assert (overflow ==
        ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]))) else $error("R6 sub");
    if (isLogic || aluCode == CODE_SLT)
      assert_no_overflow_R7: assert (!overflow) else $error("R7 ovf");
    if (!isKnown)
      assert_unused_R8: assert (result == '0 && !overflow) else $error("R8 unused");
  end

endmodule

bind alu32_top alu32_checker #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .aluCode  (aluCode),
  .result   (result),
  .zeroFlag (zeroFlag),
  .overflow (overflow)
);

// File: tb/alu32_top_tb_top.sv
module alu32_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  aluCode = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        overflow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu32_top dut_i (
    .opA      (opA),
    .opB      (opB),
    .aluCode  (aluCode),
    .result   (result),
    .zeroFlag (zeroFlag),
    .overflow (overflow)
  );

  function automatic string tagOf(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: return "R1/R7";
      4'b0110: return "R2/R6";
      4'b1110: return "R3/R6";
      4'b1111: return "R4/R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] c,
                       output logic [31:0] r, output logic o);
    longint sa, sb, wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    o = 1'b0;
    case (c)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: r = a ^ b;
      4'b0011: r = ~(a | b);
      4'b0110: begin
        wide = sa + sb;
        r = wide[31:0];
        o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'b1110: begin
        wide = sa - sb;
        r = wide[31:0];
        o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      4'b1111: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
  endtask

  task automatic applyCheck(input logic [31:0] a, input logic [31:0] b,
                            input logic [3:0] c);
    logic [31:0] expR;
    logic        expO;
    logic        expZ;
    @(negedge clk);
    opA = a; opB = b; aluCode = c;
    model(a, b, c, expR, expO);
    expZ = (expR == 32'd0);
    #1;
    compared++;
    if (result !== expR || overflow !== expO || zeroFlag !== expZ) begin
      mismatched++;
      $display("FAIL %s (zero R5) code=%b a=%h b=%h: got r=%h o=%b z=%b, expected r=%h o=%b z=%b",
               tagOf(c), c, a, b, result, overflow, zeroFlag, expR, expO, expZ);
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired: got running, expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [16];
    logic [31:0] x;
    logic [31:0] y;
    corner[0]  = 32'h0000_0000; corner[1]  = 32'h0000_0001;
    corner[2]  = 32'h0000_0002; corner[3]  = 32'h7FFF_FFFF;
    corner[4]  = 32'h8000_0000; corner[5]  = 32'h8000_0001;
    corner[6]  = 32'hFFFF_FFFF; corner[7]  = 32'hFFFF_FFFE;
    corner[8]  = 32'h7FFF_FFFE; corner[9]  = 32'h5555_5555;
    corner[10] = 32'hAAAA_AAAA; corner[11] = 32'h0000_FFFF;
    corner[12] = 32'hFFFF_0000; corner[13] = 32'h4000_0000;
    corner[14] = 32'hC000_0000; corner[15] = 32'h1234_5678;

    repeat (4) @(posedge clk);
    rstN = 1'b1;
    // idle state: zero operands with code 0 -> result 0, zero flag set (R5)
    @(negedge clk);
    compared++;
    if (result !== 32'd0 || zeroFlag !== 1'b1 || overflow !== 1'b0) begin
      mismatched++;
      $display("FAIL R5 idle: got r=%h z=%b o=%b, expected r=0 z=1 o=0",
               result, zeroFlag, overflow);
    end

    // corner sweep over all codes, includes R4 compare under overflow
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          applyCheck(corner[i], corner[j], 4'(c));

    // equal operands through subtract give zero flag (R5)
    applyCheck(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b1110);

    // pseudo-random operands
    x = 32'h1F2E_3D4C;
    y = 32'h9A8B_7C6D;
    for (int k = 0; k < 3000; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      applyCheck(x, y, y[3:0]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule